// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the register file that a processor core module exposes on its local bus. Software uses it to identify the module and to program its clock oscillators. It also drives a status LED, moves the boot flash out of address zero, asks for a system reset, and keeps scratch flags across a warm restart. The block also holds a free-running reference counter and a small software interrupt group. A read window shows the memory module's descriptor bytes.

The bus is a plain single-cycle read/write port. The address is a byte offset, and the register selected is the offset shifted right by two. Read data is combinational from the address. Writes take effect at the clock edge on which `wr_en` is sampled high. The oscillator registers are protected by a 16-bit unlock key. Flag and enable registers are changed through separate set and clear addresses and are never written directly. The memory size present is given on `mem_mb` and is folded into the SDRAM register when reset is applied.

Top module: `cmsc_sysctl`

## Requirements
- R1: Word index 0 reads 0x411A3001, index 1 reads 0 and index 4 reads 0x00100000.
- R2: A write to index 5 (lock) keeps only bits 15:0. While the lock holds 0xA05F, the lock reads 0x0001A05F; otherwise it reads the stored 16 bits, zero-extended.
- R3: Writes to the oscillator (index 2) and the auxiliary oscillator (index 7) change them only while the lock holds 0xA05F. At any other time they are dropped.
- R4: A write to index 3 (control) stores written bits 0 and 2 only, and reads back with bits 1 and 3 always zero. `led_o` follows stored bit 0. `remap_o` follows stored bit 2, where high means the boot flash is no longer mapped at address zero.
- R5: A control write with bit 3 set raises `rst_req_o` for exactly the one cycle after that write's clock edge.
- R6: Index 12 reads the flags. A write to index 12 ORs the data in, and a write to index 13 clears the bits set in the data. The non-volatile flags behave the same way at indices 14 and 15.
- R7: After reset the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, init (index 9) 0x00000112, and lock, control, flags and enables read 0. SDRAM (index 8) and init are written directly.
- R8: At reset, SDRAM reads 0x00011122 ORed with a size code taken from `mem_mb`: 0x10 for 256 or more, 0x0C for 128 to 255, 0x08 for 64 to 127, 0x04 for 32 to 63, and 0 below 32.
- R9: Byte offsets 0x100 to 0x17F read descriptor byte number (offset >> 2) in bits 7:0, with the upper bits zero. Descriptor bytes 73 to 83 hold the ASCII text "MEMORY-CARD" and the other visible bytes are zero. Offsets 0x180 to 0x1FF read zero.
- R10: Index 10 is a 32-bit counter. It reads 0 right after reset and then advances by REF_HZ/CLK_HZ counts per clock on average, for example 120 counts per 1000 clocks at 24 MHz on a 200 MHz clock.
- R11: The soft interrupt level (bit 0) is set by writing index 20 and cleared by writing index 21, in both cases only when data bit 0 is 1. Indices 17 and 25 read the raw level, and index 20 reads the level. IRQ enables read at 18, are set at 18 and cleared at 19, and index 16 reads level AND IRQ enable. FIQ enables read at 26, are set at 26 and cleared at 27, and index 24 reads level AND FIQ enable.
- R12: Indices 32 to 35 read zero and ignore writes without an error. Any other access outside the register map reads zero and raises `err_o` for one cycle after the access edge. This includes index 6, writes to read-only indices and reads of clear-only indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, used only for error reporting |
| addr | input | ADDR_W | Byte offset into the block |
| wdata | input | 32 | Write data |
| mem_mb | input | 16 | Installed memory size in MB, sampled at reset |
| rdata | output | 32 | Combinational read data for `addr` |
| led_o | output | 1 | LED drive level |
| remap_o | output | 1 | High when the boot flash is unmapped from address zero |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| err_o | output | 1 | One-cycle pulse for an access outside the map |

## Verification
The lock gate is exercised three ways: an oscillator write with no key, with the key, and after the key has been overwritten. This separates key-compare faults from faults in the stored lock value. Control writes use all of the patterns 0xF, 0x8 and 0x5. These show whether the stored-bit mask, the read-zero bit and the reset pulse are each correct. Set/clear pairs are driven with overlapping masks on both flag banks, so a bank that writes directly instead of ORing, or that swaps banks, gives different read values. The SDRAM size code is checked across four resets with sizes on both sides of every threshold, and the descriptor window is probed at both ends of its text, inside its zero half and at its edges.

// File: rtl/cmsc_pkg.sv
package cmsc_pkg;

    localparam logic [31:0] ID_WORD   = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD = 32'h0010_0000;
    localparam logic [31:0] OSC_RST   = 32'h0100_0048;
    localparam logic [31:0] AUX_RST   = 32'h0007_FEFF;
    localparam logic [31:0] SDRAM_RST = 32'h0001_1122;
    localparam logic [31:0] INIT_RST  = 32'h0000_0112;
    localparam logic [15:0] UNLOCK    = 16'hA05F;
    localparam logic [31:0] LOCK_OPEN = 32'h0001_A05F;

    // descriptor text and its first byte position
    localparam logic [87:0] DESC_TAG   = "MEMORY-CARD";
    localparam int          TAG_FIRST  = 73;
    localparam int          TAG_LEN    = 11;

    typedef enum logic [6:0] {
        IX_ID    = 7'd0,  IX_PROC  = 7'd1,  IX_OSC   = 7'd2,  IX_CTRL  = 7'd3,
        IX_STAT  = 7'd4,  IX_LOCK  = 7'd5,  IX_AUX   = 7'd7,  IX_SDRAM = 7'd8,
        IX_INIT  = 7'd9,  IX_REF   = 7'd10, IX_FLGS  = 7'd12, IX_FLGC  = 7'd13,
        IX_NVS   = 7'd14, IX_NVC   = 7'd15, IX_ISTAT = 7'd16, IX_IRAW  = 7'd17,
        IX_IENS  = 7'd18, IX_IENC  = 7'd19, IX_SWS   = 7'd20, IX_SWC   = 7'd21,
        IX_FSTAT = 7'd24, IX_FRAW  = 7'd25, IX_FENS  = 7'd26, IX_FENC  = 7'd27
    } reg_ix_e;

    typedef struct packed {
        logic remap;
        logic led;
    } ctrl_t;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        in_map;   // upper address bits are zero
        logic [6:0]  ix;
    } bus_req_t;

    localparam int NBANK   = 4;
    localparam int BK_FLAG = 0;
    localparam int BK_NV   = 1;
    localparam int BK_IRQ  = 2;
    localparam int BK_FIQ  = 3;

    function automatic logic [31:0] size_code(input logic [15:0] mb);
        if (mb >= 16'd256)      return 32'h10;
        else if (mb >= 16'd128) return 32'h0C;
        else if (mb >= 16'd64)  return 32'h08;
        else if (mb >= 16'd32)  return 32'h04;
        return 32'h0;
    endfunction

    function automatic logic [7:0] desc_byte(input logic [6:0] i);
        int k;
        k = int'(i) - TAG_FIRST;
        if (k >= 0 && k < TAG_LEN) return DESC_TAG[8*(TAG_LEN-1-k) +: 8];
        case (i)
            7'd0:    return 8'h80;
            7'd1:    return 8'h08;
            7'd2:    return 8'h04;
            7'd3:    return 8'h0B;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_volt(input logic [6:0] i);
        return (i >= 7'd32) && (i <= 7'd35);
    endfunction

    function automatic logic rd_mapped(input logic [6:0] i);
        return (i >= 7'd64) || is_volt(i) ||
               (i inside {7'd0, 7'd1, 7'd2, 7'd3, 7'd4, 7'd5, 7'd7, 7'd8, 7'd9,
                          7'd10, 7'd12, 7'd14, 7'd16, 7'd17, 7'd18, 7'd20,
                          7'd24, 7'd25, 7'd26});
    endfunction

    function automatic logic wr_mapped(input logic [6:0] i);
        return is_volt(i) ||
               (i inside {7'd2, 7'd3, 7'd5, 7'd7, 7'd8, 7'd9, 7'd12, 7'd13,
                          7'd14, 7'd15, 7'd18, 7'd19, 7'd20, 7'd21, 7'd26, 7'd27});
    endfunction

endpackage

// File: rtl/cmsc_setclr.sv
module cmsc_setclr #(
    parameter int            W       = 32,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_en ? mask : '0;
    assign clr_m = clr_en ? mask : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/cmsc_refcnt.sv
module cmsc_refcnt #(
    parameter int CLK_HZ = 48_000_000,
    parameter int REF_HZ = 24_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt
);
    localparam int ACC_W = $clog2(CLK_HZ + REF_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = acc + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else if (acc_sum >= WRAP) begin
            acc <= acc_sum - WRAP;
            cnt <= cnt + 1'b1;
        end else begin
            acc <= acc_sum;
        end
    end
endmodule

// File: rtl/cmsc_desc_win.sv
module cmsc_desc_win
    import cmsc_pkg::*;
(
    input  logic [6:0]  ix,
    output logic [31:0] val
);
    // lower half of the window shows descriptor bytes, upper half is zero
    always_comb begin
        if (ix[5]) val = '0;
        else       val = {24'h0, desc_byte(ix)};
    end
endmodule

// File: rtl/cmsc_sysctl.sv
module cmsc_sysctl
    import cmsc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CLK_HZ = 48_000_000,
    parameter int REF_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [15:0]       mem_mb,
    output logic [31:0]       rdata,
    output logic              led_o,
    output logic              remap_o,
    output logic              rst_req_o,
    output logic              err_o
);
    localparam logic [6:0] BANK_SET_IX [NBANK] = '{7'd12, 7'd14, 7'd18, 7'd26};

    bus_req_t    req;
    reg_ix_e     ixe;
    logic        wr_go;
    logic [15:0] lock_q;
    logic [31:0] osc_q, aux_q, sdram_q, init_q;
    ctrl_t       ctrl_q;
    logic [31:0] ref_cnt;
    logic [31:0] win_val;
    logic [0:0]  soft_q;
    logic [31:0] level32;
    logic [31:0] bank_q [NBANK];

    generate
        if (ADDR_W > 9) begin : g_wide
            assign req.in_map = ~|addr[ADDR_W-1:9];
        end else begin : g_narrow
            assign req.in_map = 1'b1;
        end
    endgenerate

    assign req.ix = addr[8:2];
    assign req.wr = wr_en;
    assign req.rd = rd_en;
    assign ixe    = reg_ix_e'(req.ix);
    assign wr_go  = req.wr && req.in_map;

    // set/clear banks: flags, non-volatile flags, IRQ enable, FIQ enable
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        cmsc_setclr #(.W(32)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_en (wr_go && (req.ix == BANK_SET_IX[g])),
            .clr_en (wr_go && (req.ix == BANK_SET_IX[g] + 7'd1)),
            .mask   (wdata),
            .q      (bank_q[g])
        );
    end

    cmsc_setclr #(.W(1)) u_soft (
        .clk    (clk),
        .rst    (rst),
        .set_en (wr_go && (ixe == IX_SWS)),
        .clr_en (wr_go && (ixe == IX_SWC)),
        .mask   (wdata[0]),
        .q      (soft_q)
    );
    assign level32 = {31'h0, soft_q};

    cmsc_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CNT_W(32)) u_ref (
        .clk (clk),
        .rst (rst),
        .cnt (ref_cnt)
    );

    cmsc_desc_win u_win (
        .ix  (req.ix),
        .val (win_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= '0;
            osc_q     <= OSC_RST;
            aux_q     <= AUX_RST;
            sdram_q   <= SDRAM_RST | size_code(mem_mb);
            init_q    <= INIT_RST;
            ctrl_q    <= '0;
            rst_req_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            rst_req_o <= wr_go && (ixe == IX_CTRL) && wdata[3];
            err_o     <= (req.rd && !(req.in_map && rd_mapped(req.ix))) ||
                         (req.wr && !(req.in_map && wr_mapped(req.ix)));
            if (wr_go) begin
                case (ixe)
                    IX_OSC:   if (lock_q == UNLOCK) osc_q <= wdata;
                    IX_AUX:   if (lock_q == UNLOCK) aux_q <= wdata;
                    IX_LOCK:  lock_q  <= wdata[15:0];
                    IX_CTRL:  ctrl_q  <= '{remap: wdata[2], led: wdata[0]};
                    IX_SDRAM: sdram_q <= wdata;
                    IX_INIT:  init_q  <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign led_o   = ctrl_q.led;
    assign remap_o = ctrl_q.remap;

    always_comb begin
        rdata = '0;
        if (req.in_map) begin
            if (req.ix[6]) begin
                rdata = win_val;
            end else begin
                case (ixe)
                    IX_ID:    rdata = ID_WORD;
                    IX_STAT:  rdata = STAT_WORD;
                    IX_OSC:   rdata = osc_q;
                    IX_CTRL:  rdata = {29'h0, ctrl_q.remap, 1'b0, ctrl_q.led};
                    IX_LOCK:  rdata = (lock_q == UNLOCK) ? LOCK_OPEN : {16'h0, lock_q};
                    IX_AUX:   rdata = aux_q;
                    IX_SDRAM: rdata = sdram_q;
                    IX_INIT:  rdata = init_q;
                    IX_REF:   rdata = ref_cnt;
                    IX_FLGS:  rdata = bank_q[BK_FLAG];
                    IX_NVS:   rdata = bank_q[BK_NV];
                    IX_ISTAT: rdata = bank_q[BK_IRQ] & level32;
                    IX_IRAW:  rdata = level32;
                    IX_IENS:  rdata = bank_q[BK_IRQ];
                    IX_SWS:   rdata = level32;
                    IX_FSTAT: rdata = bank_q[BK_FIQ] & level32;
                    IX_FRAW:  rdata = level32;
                    IX_FENS:  rdata = bank_q[BK_FIQ];
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmsc_sysctl_chk.sv
module cmsc_sysctl_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              led_o,
    input logic              rst_req_o,
    input logic              err_o,
    input logic [15:0]       lock_q,
    input logic [31:0]       osc_q,
    input logic [31:0]       aux_q,
    input logic [31:0]       ref_cnt
);
    logic [31:0] ixw;
    assign ixw = 32'(addr >> 2);

    AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ixw == 32'd2 && lock_q != 16'hA05F) |=> $stable(osc_q)); // R3
    AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ixw == 32'd7 && lock_q != 16'hA05F) |=> $stable(aux_q)); // R3
    AST_CTRL_B3_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ixw == 32'd3) |-> !rdata[3] && !rdata[1]); // R4
    AST_LED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ixw == 32'd3) |=> (led_o == $past(wdata[0]))); // R4
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> $past(wr_en && ixw == 32'd3 && wdata[3])); // R5
    AST_RST_RAISE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ixw == 32'd3 && wdata[3]) |=> rst_req_o); // R5
    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        (ref_cnt == $past(ref_cnt)) || (ref_cnt == $past(ref_cnt) + 32'd1)); // R10
    AST_VOLT_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && ixw >= 32'd32 && ixw <= 32'd35) |=> !err_o); // R12
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(wr_en || rd_en)); // R12
endmodule

bind cmsc_sysctl cmsc_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .led_o     (led_o),
    .rst_req_o (rst_req_o),
    .err_o     (err_o),
    .lock_q    (lock_q),
    .osc_q     (osc_q),
    .aux_q     (aux_q),
    .ref_cnt   (ref_cnt)
);

// File: tb/cmsc_sysctl_bench.sv
`timescale 1ns/1ps
module cmsc_sysctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [15:0] mem_mb = 16'd128;
    logic [31:0] rdata;
    logic        led_o, remap_o, rst_req_o, err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cmsc_sysctl #(.ADDR_W(9), .CLK_HZ(200_000_000), .REF_HZ(24_000_000)) u_cmsc_sysctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .mem_mb(mem_mb), .rdata(rdata), .led_o(led_o),
        .remap_o(remap_o), .rst_req_o(rst_req_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] mb);
        @(negedge clk);
        mem_mb = mb;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd_off(input int off, output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = 9'(off);
        rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        e = err_o;
    endtask

    task automatic rd(input int ix, output logic [31:0] d);
        logic e;
        rd_off(ix * 4, d, e);
    endtask

    task automatic wr(input int ix, input logic [31:0] v, output logic e);
        @(negedge clk);
        addr = 9'(ix * 4);
        wdata = v;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        e = err_o;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(10, d); chk("R10 counter zero after reset", d, 32'h0);
        rd(2, d);  chk("R7 osc reset", d, 32'h0100_0048);
        rd(7, d);  chk("R7 aux reset", d, 32'h0007_FEFF);
        rd(9, d);  chk("R7 init reset", d, 32'h0000_0112);
        rd(5, d);  chk("R7 lock reset", d, 32'h0);
        rd(3, d);  chk("R7 ctrl reset", d, 32'h0);
        rd(12, d); chk("R7 flags reset", d, 32'h0);
        rd(18, d); chk("R7 irq enable reset", d, 32'h0);
        rd(8, d);  chk("R8 sdram at 128MB", d, 32'h0001_112E);
        chk("R7 led low at reset", {31'h0, led_o}, 32'h0);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        rd(0, d); chk("R1 id word", d, 32'h411A_3001);
        rd(1, d); chk("R1 index1 zero", d, 32'h0);
        rd(4, d); chk("R1 status word", d, 32'h0010_0000);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        logic e;
        wr(2, 32'hDEAD_0001, e);
        rd(2, d); chk("R3 osc write dropped while locked", d, 32'h0100_0048);
        wr(5, 32'h1234_A05F, e);
        rd(5, d); chk("R2 lock open readback", d, 32'h0001_A05F);
        wr(2, 32'hDEAD_0001, e);
        rd(2, d); chk("R3 osc write with key", d, 32'hDEAD_0001);
        wr(7, 32'h0000_5555, e);
        rd(7, d); chk("R3 aux write with key", d, 32'h0000_5555);
        wr(5, 32'hFFFF_1234, e);
        rd(5, d); chk("R2 lock low 16 bits only", d, 32'h0000_1234);
        wr(7, 32'h0000_0000, e);
        rd(7, d); chk("R3 aux write dropped after relock", d, 32'h0000_5555);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        logic e;
        @(negedge clk);
        addr = 9'd12; wdata = 32'hF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 reset pulse high", {31'h0, rst_req_o}, 32'h1);
        @(negedge clk);
        chk("R5 reset pulse one cycle", {31'h0, rst_req_o}, 32'h0);
        rd(3, d); chk("R4 ctrl stores bits 0 and 2", d, 32'h5);
        chk("R4 led follows bit0", {31'h0, led_o}, 32'h1);
        chk("R4 remap follows bit2", {31'h0, remap_o}, 32'h1);
        wr(3, 32'h8, e);
        rd(3, d); chk("R4 ctrl bit3 reads zero", d, 32'h0);
        chk("R4 led off", {31'h0, led_o}, 32'h0);
        chk("R4 remap off", {31'h0, remap_o}, 32'h0);
        wr(3, 32'h5, e);
        chk("R5 no pulse without bit3", {31'h0, rst_req_o}, 32'h0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        logic e;
        wr(12, 32'h0000_00F0, e);
        wr(12, 32'h0000_0F00, e);
        rd(12, d); chk("R6 flags OR-set", d, 32'h0000_0FF0);
        wr(13, 32'h0000_0330, e);
        rd(12, d); chk("R6 flags clear", d, 32'h0000_0CC0);
        wr(14, 32'h8000_0001, e);
        rd(14, d); chk("R6 nv flags set", d, 32'h8000_0001);
        wr(15, 32'h0000_0001, e);
        rd(14, d); chk("R6 nv flags clear", d, 32'h8000_0000);
        rd(12, d); chk("R6 flags untouched by nv", d, 32'h0000_0CC0);
        wr(8, 32'hCAFE_0001, e);
        rd(8, d); chk("R7 sdram direct write", d, 32'hCAFE_0001);
        wr(9, 32'h0000_0777, e);
        rd(9, d); chk("R7 init direct write", d, 32'h0000_0777);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        logic e;
        wr(18, 32'h5, e);
        rd(18, d); chk("R11 irq enable set", d, 32'h5);
        wr(20, 32'h2, e);
        rd(17, d); chk("R11 soft set ignores bit1", d, 32'h0);
        wr(20, 32'h1, e);
        rd(17, d); chk("R11 raw level", d, 32'h1);
        rd(20, d); chk("R11 soft level read", d, 32'h1);
        rd(16, d); chk("R11 irq status", d, 32'h1);
        wr(19, 32'h1, e);
        rd(18, d); chk("R11 irq enable clear", d, 32'h4);
        rd(16, d); chk("R11 irq status masked", d, 32'h0);
        wr(26, 32'h3, e);
        rd(26, d); chk("R11 fiq enable", d, 32'h3);
        rd(24, d); chk("R11 fiq status", d, 32'h1);
        rd(25, d); chk("R11 fiq raw", d, 32'h1);
        wr(27, 32'h1, e);
        rd(24, d); chk("R11 fiq status after clear", d, 32'h0);
        wr(21, 32'h1, e);
        rd(17, d); chk("R11 soft clear", d, 32'h0);
    endtask

    task automatic t_rom();
        logic [31:0] d;
        logic e;
        rd_off(32'h124, d, e); chk("R9 first text byte", d, 32'h4D);
        rd_off(32'h14C, d, e); chk("R9 last text byte", d, 32'h44);
        rd_off(32'h13C, d, e); chk("R9 dash byte", d, 32'h2D);
        rd_off(32'h100, d, e); chk("R9 window start zero", d, 32'h0);
        rd_off(32'h17C, d, e); chk("R9 window end zero", d, 32'h0);
        rd_off(32'h180, d, e); chk("R9 upper half zero", d, 32'h0);
        chk("R9 window read no error", {31'h0, e}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic e;
        rd_off(24, d, e);
        chk("R12 index6 reads zero", d, 32'h0);
        chk("R12 index6 error", {31'h0, e}, 32'h1);
        @(negedge clk);
        chk("R12 error one cycle", {31'h0, err_o}, 32'h0);
        wr(33, 32'hFFFF_FFFF, e);
        chk("R12 voltage write no error", {31'h0, e}, 32'h0);
        rd_off(33 * 4, d, e);
        chk("R12 voltage reads zero", d, 32'h0);
        chk("R12 voltage read no error", {31'h0, e}, 32'h0);
        wr(0, 32'h1, e);
        chk("R12 write to read-only errors", {31'h0, e}, 32'h1);
        rd_off(13 * 4, d, e);
        chk("R12 read of clear-only errors", {31'h0, e}, 32'h1);
        wr(40, 32'h1, e);
        chk("R12 write unmapped errors", {31'h0, e}, 32'h1);
    endtask

    task automatic t_refcnt();
        logic [31:0] a, b;
        @(negedge clk);
        addr = 9'd40; rd_en = 1'b1;
        #1 a = rdata;
        repeat (1000) @(negedge clk);
        #1 b = rdata;
        rd_en = 1'b0;
        chk("R10 counter rate over 1000 clocks", b - a, 32'd120);
    endtask

    task automatic t_sizes();
        logic [31:0] d;
        do_reset(16'd300); rd(8, d); chk("R8 sdram 300MB", d, 32'h0001_1132);
        do_reset(16'd64);  rd(8, d); chk("R8 sdram 64MB", d, 32'h0001_112A);
        do_reset(16'd63);  rd(8, d); chk("R8 sdram 63MB", d, 32'h0001_1126);
        do_reset(16'd31);  rd(8, d); chk("R8 sdram 31MB", d, 32'h0001_1122);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(16'd128);
        t_reset_state();
        t_ident();
        t_lock();
        t_ctrl();
        t_flags();
        t_irq();
        t_rom();
        t_unmapped();
        t_refcnt();
        t_sizes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule